// File: doc/BRIEF.md
# Scan-Driven Word Access Bridge

This block is a test-access data register that converts serial scans into word-sized transfers on an internal memory bus. It sits behind a TAP controller that has already decoded its states: it receives single-cycle capture, shift and update strobes, the serial input bit and a flag saying that its instruction is the current one. It returns the serial output bit. On the bus side it raises a request with an address, a direction and write data, and it waits for a ready pulse, an error flag and read data.

A single 35-bit shift register serves two purposes. In turn it holds an address with a direction bit, and then a data word. The register starts in the address role whenever the instruction is selected. It changes role after each completed scan, but only when the status captured at the start of that scan showed the bus idle. Every captured value carries the busy and error flags in its two lowest bits, so the host can poll a slow transfer by repeating the same scan. Every transfer is a full 32-bit word.

Top module: `jtag_word_bridge`

## Requirements
- R1: After reset, `bus_req` is low and the first capture returns busy = 0 and error = 0 in bits 0 and 1.
- R2: Capture loads the shift register. Each shift cycle moves `tdi` into bit 34 and moves every bit one place toward bit 0. `tdo` always shows bit 0, so the captured value leaves least significant bit first.
- R3: An update in the address role takes bit 0 as the direction (1 = read, 0 = write) and bits 34:1 as word address bits. These appear on `bus_addr[35:2]`, and `bus_addr[1:0]` is always 0. A write direction starts no bus request.
- R4: An update in the address role with direction 1 raises a read request (`bus_we` = 0) on the next cycle. Once the read completes, the next capture in the data role returns the read word in bits 34:3, error in bit 1 and busy = 0 in bit 0.
- R5: An update in the data role after a write address raises a write request (`bus_we` = 1) on the next cycle. The request carries the word from bits 34:3 of the shifted-in value, and bits 2:0 have no effect.
- R6: In the address role and after a write address, a capture returns busy (`bus_req` pending) in bit 0, the error flag in bit 1 and zeros elsewhere.
- R7: If busy was set at the capture of a scan, the update of that scan changes neither the role nor the bus request. The role toggles only after scans captured with busy clear.
- R8: A bus request stays high with stable address, direction and write data until a cycle with `bus_rdy` high, after which it falls.
- R9: A completion with `bus_err` high sets the error flag. The flag stays set until the next accepted address-role update clears it.
- R10: While `sel` is low the register returns to the address role. The strobes have no effect while `sel` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the scan strobes and the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | The bridge instruction is the current instruction |
| cap_dr | input | 1 | Capture strobe, one cycle |
| shift_dr | input | 1 | Shift strobe, one cycle per bit |
| upd_dr | input | 1 | Update strobe, one cycle |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (shift register bit 0) |
| bus_req | output | 1 | Bus transfer request, held until ready |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 36 | Byte address, word aligned |
| bus_wdata | output | 32 | Write data |
| bus_rdy | input | 1 | Transfer complete |
| bus_err | input | 1 | Transfer failed (valid with bus_rdy) |
| bus_rdata | input | 32 | Read data (valid with bus_rdy) |

## Verification
The assertions check on every cycle that the request holds with a stable address and data until ready, and that a request only starts from an update with the instruction selected. They also check that a capture puts the current busy state on `tdo`, and that deselection forces the address role. Only the bench scenarios can show the end-to-end results. These are data written through a scan pair reading back through a later scan pair, a slow response reported busy across several polling scans without a role change, and an error flag that persists until the next address scan clears it.

// File: rtl/jwb_pkg.sv
// Shared types for the scan-driven word access bridge.
package jwb_pkg;

    // Role of the shared shift register between two completed scans.
    typedef enum logic {
        PH_ADDR = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

endpackage

// File: rtl/jwb_shift.sv
// Serial shift register of the bridge.
// Loads a parallel capture value on cap_en and shifts toward bit 0 on
// shift_en, with new bits entering at the top. Assumes the strobes are
// already gated by instruction select and never overlap.
module jwb_shift #(
    parameter int DR_W = 35
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_en,
    input  logic            shift_en,
    input  logic            tdi,
    input  logic [DR_W-1:0] cap_val,
    output logic [DR_W-1:0] sr,
    output logic            tdo
);

    // Capture or shift the scan chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (cap_en) begin
            sr <= cap_val;
        end else if (shift_en) begin
            sr <= {tdi, sr[DR_W-1:1]};
        end
    end

    // Serial output is the lowest stage.
    assign tdo = sr[0];

endmodule

// File: rtl/jwb_ctrl.sv
// Role control of the bridge.
// Tracks whether the shift register holds an address or a data word.
// Records the busy state seen at capture and decides, at update, whether
// to latch an address or start a transfer. Builds the capture value.
// Assumes each update is preceded by a capture of the same scan.
module jwb_ctrl
    import jwb_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int DR_W  = DATA_W + 3,
    localparam int SAW   = DR_W - 1,
    localparam int BAW   = SAW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              cap_dr,
    input  logic              upd_dr,
    input  logic [DR_W-1:0]   sr,
    input  logic              busy,
    input  logic              err,
    input  logic [DATA_W-1:0] rdata_q,
    output logic [DR_W-1:0]   cap_val,
    output logic              ld_addr,
    output logic [BAW-1:0]    addr_out,
    output logic              start,
    output logic              start_we,
    output logic [DATA_W-1:0] wdata_out
);

    phase_e phase;
    logic   cap_busy_q;
    logic   dir_rd_q;
    logic   act;

    // An update only acts when the scan was captured with the bus idle.
    assign act = sel && upd_dr && !cap_busy_q;

    // Remember the busy flag reported by the current scan.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            cap_busy_q <= 1'b0;
        end else if (cap_dr) begin
            cap_busy_q <= busy;
        end
    end

    // Toggle the register role after each accepted scan.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            phase <= PH_ADDR;
        end else if (act) begin
            phase <= (phase == PH_ADDR) ? PH_DATA : PH_ADDR;
        end
    end

    // Keep the direction of the pending address for the data scan.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_rd_q <= 1'b0;
        end else if (act && phase == PH_ADDR) begin
            dir_rd_q <= sr[0];
        end
    end

    // Decode update actions for the bus side.
    always_comb begin
        ld_addr   = act && (phase == PH_ADDR);
        addr_out  = {sr[SAW:1], 2'b00};
        wdata_out = sr[DR_W-1:3];
        start     = 1'b0;
        start_we  = 1'b0;
        if (act && phase == PH_ADDR && sr[0]) begin
            start = 1'b1;
        end else if (act && phase == PH_DATA && !dir_rd_q) begin
            start    = 1'b1;
            start_we = 1'b1;
        end
    end

    // Capture value: read word only in the read data role, status always.
    always_comb begin
        if (phase == PH_DATA && dir_rd_q) begin
            cap_val = {rdata_q, 1'b0, err, busy};
        end else begin
            cap_val = {{(DR_W-2){1'b0}}, err, busy};
        end
    end

    // R10: deselection forces the address role.
    p_unsel_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> phase == PH_ADDR);

    // R7: a scan captured while busy leaves the role unchanged.
    p_busy_keeps_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && upd_dr && cap_busy_q) |=> $stable(phase));

endmodule

// File: rtl/jwb_bus.sv
// Bus side of the bridge.
// Holds the latched word address, issues one request at a time, keeps it
// up until ready, and records read data and the error response.
// Assumes start is never raised while a request is pending.
module jwb_bus #(
    parameter int DATA_W = 32,
    parameter int BAW    = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_addr,
    input  logic [BAW-1:0]    addr_in,
    input  logic              start,
    input  logic              start_we,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              bus_rdy,
    input  logic              bus_err,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [BAW-1:0]    bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              busy,
    output logic              err,
    output logic [DATA_W-1:0] rdata_q
);

    logic done;

    assign done = bus_req && bus_rdy;
    assign busy = bus_req;

    // Latch the word address of an accepted address scan.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_addr <= '0;
        end else if (ld_addr) begin
            bus_addr <= addr_in;
        end
    end

    // Request handshake: raise on start, drop on ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_req   <= 1'b0;
            bus_we    <= 1'b0;
            bus_wdata <= '0;
        end else if (start) begin
            bus_req <= 1'b1;
            bus_we  <= start_we;
            if (start_we) begin
                bus_wdata <= wdata_in;
            end
        end else if (done) begin
            bus_req <= 1'b0;
        end
    end

    // Keep the word returned by the last completed read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (done && !bus_we) begin
            rdata_q <= bus_rdata;
        end
    end

    // Error flag: set by a failed transfer, cleared by a new address.
    always_ff @(posedge clk) begin
        if (!rst_n || ld_addr) begin
            err <= 1'b0;
        end else if (done && bus_err) begin
            err <= 1'b1;
        end
    end

    // R8: a pending request holds its attributes until ready.
    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_rdy) |=> (bus_req && $stable(bus_addr)
                                   && $stable(bus_we) && $stable(bus_wdata)));

    // R9: the error flag never rises without a failed completion.
    p_err_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(bus_req && bus_rdy && bus_err));

endmodule

// File: rtl/jtag_word_bridge.sv
// Top of the scan-driven word access bridge.
// Connects the shift register, the role control and the bus side.
// Assumes strobes come from an already decoded TAP in the clk domain.
module jtag_word_bridge #(
    parameter int DATA_W = 32,
    localparam int DR_W  = DATA_W + 3,
    localparam int SAW   = DR_W - 1,
    localparam int BAW   = SAW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              cap_dr,
    input  logic              shift_dr,
    input  logic              upd_dr,
    input  logic              tdi,
    output logic              tdo,
    output logic              bus_req,
    output logic              bus_we,
    output logic [BAW-1:0]    bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rdy,
    input  logic              bus_err,
    input  logic [DATA_W-1:0] bus_rdata
);

    logic [DR_W-1:0]   sr;
    logic [DR_W-1:0]   cap_val;
    logic              ld_addr;
    logic [BAW-1:0]    addr_nx;
    logic              start;
    logic              start_we;
    logic [DATA_W-1:0] wdata_nx;
    logic              busy;
    logic              err;
    logic [DATA_W-1:0] rdata_q;

    jwb_shift #(.DR_W(DR_W)) i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (sel && cap_dr),
        .shift_en (sel && shift_dr),
        .tdi      (tdi),
        .cap_val  (cap_val),
        .sr       (sr),
        .tdo      (tdo)
    );

    jwb_ctrl #(.DATA_W(DATA_W)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .cap_dr    (cap_dr),
        .upd_dr    (upd_dr),
        .sr        (sr),
        .busy      (busy),
        .err       (err),
        .rdata_q   (rdata_q),
        .cap_val   (cap_val),
        .ld_addr   (ld_addr),
        .addr_out  (addr_nx),
        .start     (start),
        .start_we  (start_we),
        .wdata_out (wdata_nx)
    );

    jwb_bus #(.DATA_W(DATA_W), .BAW(BAW)) i_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_addr   (ld_addr),
        .addr_in   (addr_nx),
        .start     (start),
        .start_we  (start_we),
        .wdata_in  (wdata_nx),
        .bus_rdy   (bus_rdy),
        .bus_err   (bus_err),
        .bus_rdata (bus_rdata),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .err       (err),
        .rdata_q   (rdata_q)
    );

    // R7: a request only starts from a selected update strobe.
    p_req_from_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(sel && upd_dr));

    // R6: a capture presents the busy state on the serial output.
    p_capture_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && cap_dr) |=> tdo == $past(bus_req));

    // R3: the bus address is always word aligned.
    p_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> bus_addr[1:0] == 2'b00);

endmodule

// File: tb/test_jtag_word_bridge.sv
module test_jtag_word_bridge;

    localparam int CLK_P   = 10;
    localparam int DR_W    = 35;
    localparam logic [29:0] HI = 30'h2A5A_5A5C;
    localparam logic [3:0]  ERR_IDX = 4'd15;

    typedef struct packed {
        logic [3:0]  idx;
        logic [31:0] dat;
        logic [7:0]  lat;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{4'd0,  32'hDEAD_BEEF, 8'd0},
        '{4'd1,  32'h0000_0001, 8'd1},
        '{4'd7,  32'h8000_0000, 8'd2},
        '{4'd9,  32'hFFFF_FFFF, 8'd0},
        '{4'd12, 32'h1234_5678, 8'd3},
        '{4'd14, 32'hA5A5_0F0F, 8'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0, cap_dr = 1'b0, shift_dr = 1'b0, upd_dr = 1'b0, tdi = 1'b0;
    logic tdo, bus_req, bus_we;
    logic [35:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic bus_rdy, bus_err;

    int total = 0;
    int bad = 0;
    int lat = 0;
    int wcnt = 0;
    logic [31:0] mem [16];

    always #(CLK_P/2) clk = ~clk;

    jtag_word_bridge i_jtag_word_bridge (
        .clk(clk), .rst_n(rst_n), .sel(sel), .cap_dr(cap_dr),
        .shift_dr(shift_dr), .upd_dr(upd_dr), .tdi(tdi), .tdo(tdo),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdy(bus_rdy), .bus_err(bus_err),
        .bus_rdata(bus_rdata)
    );

    // Behavioural memory with programmable wait and one failing word.
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_rdy <= 1'b0;
            bus_err <= 1'b0;
            bus_rdata <= '0;
            wcnt <= 0;
        end else if (bus_req && !bus_rdy) begin
            if (wcnt >= lat) begin
                bus_rdy <= 1'b1;
                bus_err <= (bus_addr[5:2] == ERR_IDX);
                bus_rdata <= mem[bus_addr[5:2]];
                if (bus_we && bus_addr[5:2] != ERR_IDX) mem[bus_addr[5:2]] <= bus_wdata;
                wcnt <= 0;
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            bus_rdy <= 1'b0;
            bus_err <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One full scan: capture, 35 shifts, update; returns at the negedge after update.
    task automatic scan(input logic [DR_W-1:0] din, output logic [DR_W-1:0] dout);
        @(negedge clk) cap_dr = 1'b1;
        @(negedge clk) cap_dr = 1'b0;
        shift_dr = 1'b1;
        for (int i = 0; i < DR_W; i++) begin
            tdi = din[i];
            dout[i] = tdo;
            @(negedge clk);
        end
        shift_dr = 1'b0;
        upd_dr = 1'b1;
        @(negedge clk) upd_dr = 1'b0;
    endtask

    task automatic wait_idle();
        while (bus_req) @(negedge clk);
    endtask

    function automatic logic [DR_W-1:0] adr(input logic [3:0] idx, input logic rd);
        return {HI, idx, rd};
    endfunction

    function automatic logic [35:0] baddr(input logic [3:0] idx);
        return {HI, idx, 2'b00};
    endfunction

    initial begin
        #(CLK_P * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [DR_W-1:0] d;
        int polls;
        for (int i = 0; i < 16; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(bus_req == 1'b0, "R1 no request after reset", bus_req, 0);
        // R10: strobes ignored while deselected
        scan(adr(4'd2, 1'b1), d);
        chk(bus_req == 1'b0, "R10 update ignored when deselected", bus_req, 0);
        sel = 1'b1;
        @(negedge clk);
        scan(adr(4'd2, 1'b0), d);
        chk(d[1:0] == 2'b00, "R1 first capture status clear", d[1:0], 0);
        chk(bus_req == 1'b0, "R3 write address starts no request", bus_req, 0);
        sel = 1'b0;
        repeat (2) @(negedge clk);
        sel = 1'b1;

        // Table walk: write then read back, R2 R3 R4 R5 R6
        for (int v = 0; v < 6; v++) begin
            lat = int'(VEC[v].lat);
            scan(adr(VEC[v].idx, 1'b0), d);
            chk(d == '0, "R6 address capture zero with idle status", d, 0);
            scan({VEC[v].dat, 3'b101}, d);
            chk(d == '0, "R6 write data capture zero", d, 0);
            chk(bus_req && bus_we, "R5 write request raised", {bus_req, bus_we}, 2'b11);
            chk(bus_addr == baddr(VEC[v].idx), "R3 write address", bus_addr, baddr(VEC[v].idx));
            chk(bus_wdata == VEC[v].dat, "R5 write data, low bits ignored", bus_wdata, VEC[v].dat);
            wait_idle();
            scan(adr(VEC[v].idx, 1'b1), d);
            chk(bus_req && !bus_we, "R4 read request raised", {bus_req, bus_we}, 2'b10);
            chk(bus_addr == baddr(VEC[v].idx), "R3 read address", bus_addr, baddr(VEC[v].idx));
            polls = 0;
            do begin
                scan('0, d);
                polls++;
            end while (d[0] && polls < 20);
            chk(d[34:3] == VEC[v].dat && d[2:0] == 3'b000, "R2 R4 read back word", d, {VEC[v].dat, 3'b000});
        end

        // R7 R8: slow write, then a scan while busy is ignored
        lat = 100;
        scan(adr(4'd3, 1'b0), d);
        scan({32'hC0DE_F00D, 3'b000}, d);
        scan(adr(4'd5, 1'b1), d);
        chk(d[1:0] == 2'b01, "R7 busy reported during slow write", d[1:0], 2'b01);
        chk(bus_req && bus_we && bus_addr == baddr(4'd3), "R7 R8 request unchanged by busy scan",
            {bus_req, bus_we, bus_addr}, {2'b11, baddr(4'd3)});
        wait_idle();
        @(negedge clk);
        chk(bus_req == 1'b0, "R8 request drops after ready", bus_req, 0);
        scan(adr(4'd3, 1'b1), d);
        chk(bus_req && !bus_we && bus_addr == baddr(4'd3), "R7 role kept after busy scan",
            {bus_req, bus_we, bus_addr}, {2'b10, baddr(4'd3)});
        scan('0, d);
        chk(d[0] == 1'b1, "R7 busy across poll scan", d[0], 1);
        polls = 0;
        do begin
            scan('0, d);
            polls++;
        end while (d[0] && polls < 20);
        chk(d[34:3] == 32'hC0DE_F00D, "R4 R7 slow read data", d[34:3], 32'hC0DE_F00D);

        // R9: error response latched until next address scan
        lat = 1;
        scan(adr(ERR_IDX, 1'b1), d);
        polls = 0;
        do begin
            scan('0, d);
            polls++;
        end while (d[0] && polls < 20);
        chk(d[1] == 1'b1, "R9 error reported", d[1], 1);
        scan(adr(4'd2, 1'b0), d);
        chk(d[1:0] == 2'b10, "R9 error kept until address update", d[1:0], 2'b10);
        scan({32'h5555_AAAA, 3'b111}, d);
        chk(d[1:0] == 2'b00, "R9 error cleared by address update", d[1:0], 0);
        wait_idle();

        // R10: deselect returns to address role
        scan(adr(4'd4, 1'b1), d);
        wait_idle();
        sel = 1'b0;
        repeat (2) @(negedge clk);
        sel = 1'b1;
        scan(adr(4'd6, 1'b1), d);
        chk(bus_req && !bus_we && bus_addr == baddr(4'd6), "R10 address role after reselect",
            {bus_req, bus_we, bus_addr}, {2'b10, baddr(4'd6)});
        wait_idle();
        scan('0, d);
        chk(d[34:3] == 32'h0 && d[1:0] == 2'b00, "R4 read of unwritten word", d, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule